// File: doc/BRIEF.md
# Clock-synchronous serial transceiver

This block is a master-side synchronous serial port. It produces its own transfer clock from the system clock through a programmable divider. On every frame it shifts eight data bits out on a transmit line and eight bits in from a receive line. The host side has a plain register-style interface. The host writes a byte to send, reads the byte that was received, and watches the busy, done, receive-valid and overrun flags.

Each bit occupies one cell of the transfer clock. The leading edge of a cell, which is the first edge away from the idle level, launches the transmit bit. The trailing edge, which returns the clock to the idle level, samples the receive line. One polarity input sets the idle level and the direction of both edges together. Run-time inputs select the bit order and an optional logical inversion of both data lines. Transmit and receive have separate enables. A 3-bit mode field switches the whole interface on or off.

To recover from an error, software clears both enables, writes the mode field to off, writes it back to the synchronous setting and then sets the enables again. Setting the mode to off clears every frame, shift and status state.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the block is idle with `busy_o`, `done_o`, `rx_valid_o` and `overrun_o` low, `rdata_o` zero, `txd_o` high, and `sclk_o` at the idle level of the current polarity.
- R2: With `clk_pol_i` = 0 the clock line idles high. Each cell starts with a falling edge that launches the transmit bit and ends with a rising edge that samples `rxd_i`.
- R3: With `clk_pol_i` = 1 the clock line idles low. Each cell starts with a rising edge that launches the transmit bit and ends with a falling edge that samples `rxd_i`.
- R4: While no frame is running, a change of `clk_pol_i` moves `sclk_o` to the new idle level in the same cycle.
- R5: With `msb_first_i` = 0 the frame carries bit 0 first and bit 7 last, both on `txd_o` and on `rxd_i`. With `msb_first_i` = 1 it carries bit 7 first.
- R6: With `invert_i` = 1 the level driven on `txd_o` is the complement of the data bit. The received byte is the complement of the levels seen on `rxd_i`.
- R7: A frame of exactly eight cells starts only when the mode field is 001, `tx_en_i` is high and a byte has been written with `wr_i`. If `tx_en_i` is low, a written byte stays pending and no clock edge appears.
- R8: At the end of a frame with `rx_en_i` high, the received byte appears on `rdata_o` and `rx_valid_o` rises. With `rx_en_i` low, `rdata_o` and `rx_valid_o` are left unchanged. A `rd_i` pulse clears `rx_valid_o`.
- R9: `done_o` is high for exactly one cycle, in the first cycle after the frame's eighth cell ends.
- R10: If a received byte completes while `rx_valid_o` is still set and `rd_i` is not asserted in that cycle, `overrun_o` rises. It stays high until the mode field leaves 001.
- R11: Any mode value other than 001 aborts a running frame and clears the pending transmit byte, `rdata_o`, `rx_valid_o`, `overrun_o` and `done_o`. It also returns `sclk_o` to the idle level.
- R12: Each half of a cell lasts `div_i`+1 system clocks, so a frame lasts 16·(`div_i`+1) cycles from its first leading edge to `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Interface mode; 001 = synchronous, any other value = off |
| tx_en_i | input | 1 | Transmit enable; allows frames to start |
| rx_en_i | input | 1 | Receive enable; allows capture of received bits |
| clk_pol_i | input | 1 | Clock polarity (0: idle high, launch on fall; 1: idle low, launch on rise) |
| msb_first_i | input | 1 | Bit order (0: bit 0 first; 1: bit 7 first) |
| invert_i | input | 1 | Inverts transmit and receive data when set |
| div_i | input | DIV_W | Half-cell length minus one, in system clocks |
| wr_i | input | 1 | Write strobe for the transmit byte |
| wdata_i | input | DATA_W | Transmit byte |
| rd_i | input | 1 | Read strobe; clears the receive-valid flag |
| rdata_o | output | DATA_W | Last received byte |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after a frame ends |
| overrun_o | output | 1 | A received byte was lost |
| rx_valid_o | output | 1 | Unread received byte available |
| sclk_o | output | 1 | Transfer clock line |
| txd_o | output | 1 | Transmit data line |
| rxd_i | input | 1 | Receive data line |

## Verification
The hardest condition to reach from the ports is an abort in the middle of a frame that leaves a stale byte pending. The bench sets a slow divider, starts a frame and moves the mode field to off while the clock line is partway through a cell. It restores the mode with the transmit enable still high and then watches that no further frame starts. An overrun also needs two complete receptions with no read between them, so the bench runs two back-to-back frames and never pulses the read strobe. A small slave model in the bench drives the receive line on every leading edge, in the order and inversion that the current vector selects.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
   localparam int unsigned SSX_FRAME_BITS = 8;

   typedef enum logic [2:0] {
      SSX_MODE_OFF  = 3'b000,
      SSX_MODE_SYNC = 3'b001
   } ssx_mode_e;
endpackage

// File: rtl/ssx_timing.sv
// Cell sequencer: divider, half-cell phase, bit counter and frame events.
module ssx_timing #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_i,
   input  logic                       start_i,
   input  logic [DIV_W-1:0]           div_i,
   output logic                       busy_o,
   output logic                       half_o,
   output logic [$clog2(DATA_W)-1:0]  bit_o,
   output logic                       sample_o,
   output logic                       adv_o,
   output logic                       end_o
);
   localparam int unsigned BIT_W = $clog2(DATA_W);
   localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

   logic             busy_q, half_q;
   logic [DIV_W-1:0] hcnt_q;
   logic [BIT_W-1:0] bit_q;
   logic             tick, last;

   assign tick = busy_q && (hcnt_q >= div_i);
   assign last = (bit_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         half_q <= 1'b0;
         hcnt_q <= '0;
         bit_q  <= '0;
      end else if (clr_i) begin
         busy_q <= 1'b0;
         half_q <= 1'b0;
         hcnt_q <= '0;
         bit_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            half_q <= 1'b0;
            hcnt_q <= '0;
            bit_q  <= '0;
         end
      end else if (tick) begin
         hcnt_q <= '0;
         if (!half_q) begin
            half_q <= 1'b1;
         end else if (last) begin
            busy_q <= 1'b0;
         end else begin
            bit_q  <= bit_q + 1'b1;
            half_q <= 1'b0;
         end
      end else begin
         hcnt_q <= hcnt_q + 1'b1;
      end
   end

   assign busy_o   = busy_q;
   assign half_o   = half_q;
   assign bit_o    = bit_q;
   assign sample_o = tick && !half_q;
   assign adv_o    = tick && half_q && !last;
   assign end_o    = tick && half_q && last;

   p_clr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !busy_q);
   p_half_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !tick && !clr_i |=> $stable(half_q) && $stable(bit_q));
   p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !end_o && !clr_i |=> busy_q);
endmodule

// File: rtl/ssx_datapath.sv
// Transmit holding and shift registers, receive assembly and status flags.
module ssx_datapath #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          ORDER_SEL = 1'b1,
   parameter bit          INV_SEL   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_i,
   input  logic                       msb_first_i,
   input  logic                       invert_i,
   input  logic                       wr_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic                       rd_i,
   input  logic                       rx_en_i,
   input  logic                       rxd_i,
   input  logic                       start_i,
   input  logic                       sample_i,
   input  logic                       adv_i,
   input  logic                       end_i,
   input  logic [$clog2(DATA_W)-1:0]  bit_i,
   output logic                       tx_full_o,
   output logic                       txd_o,
   output logic [DATA_W-1:0]          rdata_o,
   output logic                       rx_valid_o,
   output logic                       overrun_o,
   output logic                       done_o
);
   localparam int unsigned BIT_W = $clog2(DATA_W);
   localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

   logic msb_eff, inv_eff;

   generate
      if (ORDER_SEL) begin : g_order_sel
         assign msb_eff = msb_first_i;
      end else begin : g_order_fixed
         assign msb_eff = 1'b0;
      end
      if (INV_SEL) begin : g_inv_sel
         assign inv_eff = invert_i;
      end else begin : g_inv_fixed
         assign inv_eff = 1'b0;
      end
   endgenerate

   function automatic logic [BIT_W-1:0] bit_pos(input logic [BIT_W-1:0] b,
                                                input logic m);
      return m ? (LAST - b) : b;
   endfunction

   logic [DATA_W-1:0] tx_hold_q, tx_sh_q, rx_sh_q, rdata_q;
   logic              tx_full_q, txd_q, rx_full_q, ovr_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold_q <= '0;
         tx_sh_q   <= '0;
         rx_sh_q   <= '0;
         rdata_q   <= '0;
         tx_full_q <= 1'b0;
         txd_q     <= 1'b1;
         rx_full_q <= 1'b0;
         ovr_q     <= 1'b0;
         done_q    <= 1'b0;
      end else if (clr_i) begin
         tx_hold_q <= '0;
         tx_sh_q   <= '0;
         rx_sh_q   <= '0;
         rdata_q   <= '0;
         tx_full_q <= 1'b0;
         txd_q     <= 1'b1;
         rx_full_q <= 1'b0;
         ovr_q     <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= end_i;
         if (start_i) begin
            tx_sh_q   <= tx_hold_q;
            tx_full_q <= 1'b0;
            txd_q     <= tx_hold_q[bit_pos(BIT_W'(0), msb_eff)] ^ inv_eff;
         end
         if (wr_i) begin
            tx_hold_q <= wdata_i;
            tx_full_q <= 1'b1;
         end
         if (adv_i) begin
            txd_q <= tx_sh_q[bit_pos(bit_i + 1'b1, msb_eff)] ^ inv_eff;
         end
         if (end_i) begin
            txd_q <= 1'b1;
         end
         if (sample_i && rx_en_i) begin
            rx_sh_q[bit_pos(bit_i, msb_eff)] <= rxd_i ^ inv_eff;
         end
         if (end_i && rx_en_i) begin
            rdata_q   <= rx_sh_q;
            rx_full_q <= 1'b1;
            if (rx_full_q && !rd_i) begin
               ovr_q <= 1'b1;
            end
         end else if (rd_i) begin
            rx_full_q <= 1'b0;
         end
      end
   end

   assign tx_full_o  = tx_full_q;
   assign txd_o      = txd_q;
   assign rdata_o    = rdata_q;
   assign rx_valid_o = rx_full_q;
   assign overrun_o  = ovr_q;
   assign done_o     = done_q;

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q && !clr_i |=> ovr_q);
   p_txd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i && !adv_i && !end_i && !clr_i |=> $stable(txd_q));
   p_rx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_i && !rd_i && !clr_i |=> $stable(rdata_q) && $stable(rx_full_q));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
   parameter int unsigned DATA_W    = ssx_pkg::SSX_FRAME_BITS,
   parameter int unsigned DIV_W     = 8,
   parameter bit          ORDER_SEL = 1'b1,
   parameter bit          INV_SEL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              tx_en_i,
   input  logic              rx_en_i,
   input  logic              clk_pol_i,
   input  logic              msb_first_i,
   input  logic              invert_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              overrun_o,
   output logic              rx_valid_o,
   output logic              sclk_o,
   output logic              txd_o,
   input  logic              rxd_i
);
   import ssx_pkg::*;

   localparam int unsigned BIT_W = $clog2(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sync_serial_xcvr: DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("sync_serial_xcvr: DIV_W must be at least 1");
      end
   endgenerate

   logic             mode_on, clr, start;
   logic             busy, half, tx_full;
   logic             sample, adv, fend;
   logic [BIT_W-1:0] bit_idx;

   assign mode_on = (mode_i == SSX_MODE_SYNC);
   assign clr     = !mode_on;
   assign start   = mode_on && tx_en_i && tx_full && !busy;

   ssx_timing #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .start_i  (start),
      .div_i    (div_i),
      .busy_o   (busy),
      .half_o   (half),
      .bit_o    (bit_idx),
      .sample_o (sample),
      .adv_o    (adv),
      .end_o    (fend)
   );

   ssx_datapath #(.DATA_W(DATA_W), .ORDER_SEL(ORDER_SEL), .INV_SEL(INV_SEL)) u_data (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr),
      .msb_first_i (msb_first_i),
      .invert_i    (invert_i),
      .wr_i        (wr_i && mode_on),
      .wdata_i     (wdata_i),
      .rd_i        (rd_i),
      .rx_en_i     (rx_en_i),
      .rxd_i       (rxd_i),
      .start_i     (start),
      .sample_i    (sample),
      .adv_i       (adv),
      .end_i       (fend),
      .bit_i       (bit_idx),
      .tx_full_o   (tx_full),
      .txd_o       (txd_o),
      .rdata_o     (rdata_o),
      .rx_valid_o  (rx_valid_o),
      .overrun_o   (overrun_o),
      .done_o      (done_o)
   );

   // Leading half of a cell sits away from the idle level; idle is ~clk_pol_i.
   assign sclk_o = (busy && !half) ^ !clk_pol_i;
   assign busy_o = busy;

   p_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !(tx_en_i && tx_full) |=> !busy_o);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
endmodule

// File: tb/tb_sync_serial_xcvr.sv
`timescale 1ns/1ps
module tb_sync_serial_xcvr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'b000;
   logic       tx_en = 1'b0, rx_en = 1'b0, pol = 1'b0, msb = 1'b0, inv = 1'b0;
   logic [7:0] div = 8'd0;
   logic       wr = 1'b0, rd = 1'b0, rxd = 1'b1;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       busy, done, overrun, rx_valid, sclk, txd;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sync_serial_xcvr dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .tx_en_i(tx_en), .rx_en_i(rx_en),
      .clk_pol_i(pol), .msb_first_i(msb), .invert_i(inv), .div_i(div),
      .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .busy_o(busy),
      .done_o(done), .overrun_o(overrun), .rx_valid_o(rx_valid), .sclk_o(sclk),
      .txd_o(txd), .rxd_i(rxd)
   );

   // {pol, msb, inv, rx_en, div[3:0], tx byte, slave byte}
   localparam logic [23:0] VECS [0:5] = '{
      {1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'hA5, 8'h3C},
      {1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 8'h96, 8'hC1},
      {1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 8'h81, 8'h7E},
      {1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 8'h5A, 8'h0F},
      {1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 8'hFF, 8'h00},
      {1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 8'h12, 8'hE7}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic do_frame(input logic p, m, iv, re, input logic [3:0] dv,
                           input logic [7:0] txb, slb, exp_rd,
                           input logic exp_valid);
      int leads = 0;
      int t0 = -1;
      int t1 = -1;
      logic prev_act = 1'b0;
      @(negedge clk);
      pol = p; msb = m; inv = iv; rx_en = re; div = {4'd0, dv}; tx_en = 1'b1; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      chk(sclk == !p, p ? "R3 idle level low" : "R2 idle level high", sclk, !p);
      wr = 1'b1; wdata = txb;
      @(negedge clk);
      wr = 1'b0;
      for (int c = 0; c < 3000; c++) begin
         logic act;
         act = (sclk != !p);
         if (act && !prev_act) begin
            int idx;
            idx = m ? 7 - leads : leads;
            chk(txd == (txb[idx] ^ iv), "R5/R6 launched txd bit", txd, txb[idx] ^ iv);
            rxd = slb[idx] ^ iv;
            if (leads == 0) t0 = c;
            leads++;
         end
         prev_act = act;
         if (done) begin
            t1 = c;
            break;
         end
         @(negedge clk);
      end
      chk(leads == 8, "R7 eight cells per frame", leads, 8);
      chk((t1 - t0) == 16 * (int'(dv) + 1), "R12 frame length", t1 - t0, 16 * (int'(dv) + 1));
      @(negedge clk);
      chk(done == 1'b0, "R9 done single cycle", done, 0);
      chk(rdata == exp_rd, "R8 received byte", rdata, exp_rd);
      chk(rx_valid == exp_valid, "R8 receive valid", rx_valid, exp_valid);
      chk(sclk == !p && busy == 1'b0, "R2/R3 idle after frame", {busy, sclk}, {1'b0, !p});
   endtask

   initial begin
      #1ms;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] last_rd;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sclk == 1'b1, "R1 sclk idle", sclk, 1);
      chk({busy, done, rx_valid, overrun} == 4'b0, "R1 flags clear",
          {busy, done, rx_valid, overrun}, 0);
      chk(rdata == 8'h00 && txd == 1'b1, "R1 rdata and txd", {rdata, txd}, 9'h001);
      mode = 3'b001;
      @(negedge clk);

      // R4 idle polarity change
      pol = 1'b1; #1;
      chk(sclk == 1'b0, "R4 idle follows pol=1", sclk, 0);
      pol = 1'b0; #1;
      chk(sclk == 1'b1, "R4 idle follows pol=0", sclk, 1);

      // Vector table
      last_rd = 8'h00;
      for (int i = 0; i < 6; i++) begin
         logic [23:0] v;
         logic [7:0]  er;
         v  = VECS[i];
         er = v[20] ? v[7:0] : last_rd;
         do_frame(v[23], v[22], v[21], v[20], v[19:16], v[15:8], v[7:0], er, v[20]);
         last_rd = er;
      end

      // R7 transmit enable gates the start
      @(negedge clk);
      pol = 1'b0; msb = 1'b0; inv = 1'b0; div = 8'd1; rx_en = 1'b1; tx_en = 1'b0;
      wr = 1'b1; wdata = 8'h55;
      @(negedge clk);
      wr = 1'b0;
      repeat (40) @(negedge clk);
      chk(busy == 1'b0 && sclk == 1'b1, "R7 no frame while tx disabled", {busy, sclk}, 2'b01);
      tx_en = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 1'b1, "R7 pending byte starts on enable", busy, 1);
      wait_done(n);
      @(negedge clk);
      chk(rx_valid == 1'b1, "R8 valid after capture", rx_valid, 1);
      chk(overrun == 1'b0, "R10 no overrun yet", overrun, 0);

      // R10 second frame without read
      wr = 1'b1; wdata = 8'hC3;
      @(negedge clk);
      wr = 1'b0;
      @(negedge clk);
      wait_done(n);
      @(negedge clk);
      chk(overrun == 1'b1, "R10 overrun on unread byte", overrun, 1);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      chk(overrun == 1'b1 && rx_valid == 1'b0, "R10 overrun sticky, read clears valid",
          {overrun, rx_valid}, 2'b10);

      // R11 recovery sequence clears status
      tx_en = 1'b0; rx_en = 1'b0;
      @(negedge clk);
      mode = 3'b000;
      @(negedge clk);
      chk(overrun == 1'b0 && rx_valid == 1'b0 && rdata == 8'h00, "R11 mode off clears status",
          {overrun, rx_valid, rdata}, 0);
      mode = 3'b001; tx_en = 1'b1; rx_en = 1'b1;
      @(negedge clk);

      // R11 abort mid-frame and pending byte dropped
      div = 8'd3;
      wr = 1'b1; wdata = 8'hF0;
      @(negedge clk);
      wr = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy == 1'b1, "R11 frame running before abort", busy, 1);
      wr = 1'b1; wdata = 8'h0F;
      @(negedge clk);
      wr = 1'b0;
      mode = 3'b000;
      @(negedge clk);
      chk(busy == 1'b0 && sclk == 1'b1 && txd == 1'b1, "R11 abort idles lines",
          {busy, sclk, txd}, 3'b011);
      mode = 3'b001;
      repeat (40) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R11 pending byte cleared", {busy, done}, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule